// File: doc/BRIEF.md
# Dual-Identity I2C Register Target

This block is an I2C target that answers to two 7-bit identifiers on one bus. One identifier opens a register bank and the other opens a user SRAM. Both spaces sit outside the block, behind one synchronous memory port. The block samples SCL and SDA on the system clock and finds START and STOP conditions. It shifts in the identification byte, a word-address byte and data bytes. It pulls SDA low for acknowledges and for zero data bits, and it never drives SDA high.

A single byte-wide word pointer is shared by both spaces. It is zero after reset. A write loads it from the word-address byte, and it then advances after every byte moved in either direction. A host sets up a random read in two steps. It first writes an identifier and a word address with no data. It then issues a repeated START with the read identifier of the same space. A read that has no address phase continues from wherever the pointer stands. The memory port returns read data on the clock after `mem_rd`.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset `sda_oe` is 0, neither memory strobe is active, and the word pointer is 00h.
- R2: The first byte after a START carries the identifier in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). Identifier 1101111 selects space 0 (register bank) and 1010111 selects space 1 (SRAM). Either identifier is acknowledged by pulling SDA low during the ninth clock.
- R3: Any other identifier is not acknowledged. The block then leaves SDA released and raises no memory strobe until the next START.
- R4: In a write, the word-address byte is acknowledged and loaded into the pointer. Each data byte is acknowledged and is written during its acknowledge clock by a one-cycle `mem_wr` pulse carrying the space, the pointer and the byte. `mem_wr` and `mem_rd` are never high in the same cycle.
- R5: The pointer advances by one after every byte written or read, and it wraps from FFh to 00h.
- R6: A read with no preceding address phase starts at the current pointer. Data bits leave MSB first.
- R7: A random read is a write of an identifier plus a word address, then a repeated START with the same identifier in read mode. It returns data from that address. Each byte the master acknowledges is followed by the next location.
- R8: If the repeated-START read after such a dummy write uses the other space's identifier, that read is not acknowledged.
- R9: When the master does not acknowledge a read byte, SDA stays released until the next START or STOP.
- R10: A START or STOP that arrives before all eight bits of a data byte are in discards that byte, and nothing is written.
- R11: SDA is only ever pulled low through `sda_oe`. A STOP leaves `sda_oe` at 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe; data is expected on the next clock |
| mem_space | output | 1 | 0 = register bank, 1 = user SRAM |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |

## Verification
A bus condition can land in the same stretch of a byte where a data byte would otherwise finish and be committed. The abort path and the write commit therefore compete for the same state. The bench provokes this in two ways: it cuts a data byte after three bits with a STOP, and it cuts another after seven bits with a repeated START that goes straight into a read. The scoreboard must stay empty, and the read must return the untouched location that the interrupted address phase pointed at. This shows that the pointer was loaded but no write landed.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } dt_state_e;

  typedef enum logic {
    SP_REG  = 1'b0,
    SP_SRAM = 1'b1
  } dt_space_e;

endpackage

// File: rtl/i2c_dt_sync.sv
module i2c_dt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_dt_cond.sv
module i2c_dt_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start,
  output logic stop
);

  // SDA moving while SCL is high marks a bus condition
  assign start = scl_lvl & sda_fall;
  assign stop  = scl_lvl & sda_rise;

endmodule

// File: rtl/i2c_dt_shift.sv
module i2c_dt_shift #(
  parameter int unsigned BITS  = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_cnt,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic             tx_load,
  input  logic [BITS-1:0]  tx_val,
  input  logic             tx_shift,
  output logic [BITS-1:0]  rx_byte,
  output logic             tx_next,
  output logic [CNT_W-1:0] bit_cnt
);

  logic [BITS-1:0]  rx_q;
  logic [BITS-2:0]  tx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (rx_en) begin
        rx_q <= {rx_q[BITS-2:0], rx_bit};
      end
      if (clr_cnt) begin
        cnt_q <= '0;
      end else if (rx_en && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
      // bit BITS-1 goes straight to the pad at load; only the rest is kept
      if (tx_load) begin
        tx_q <= tx_val[BITS-2:0];
      end else if (tx_shift) begin
        tx_q <= {tx_q[BITS-3:0], 1'b0};
      end
    end
  end

  assign rx_byte = rx_q;
  assign tx_next = tx_q[BITS-2];
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
  import i2c_dt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  ID_REG      = 7'b1101111,
  parameter logic [6:0]  ID_SRAM     = 7'b1010111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int unsigned LINES = 2;
  localparam int unsigned L_SCL = 0;
  localparam int unsigned L_SDA = 1;

  // ---------------------------------------------------------------- sampling
  logic [LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (line_in[g]),
      .lvl  (line_lvl[g]),
      .rise (line_rise[g]),
      .fall (line_fall[g])
    );
  end

  logic scl_rise, scl_fall, sda_lvl, start, stop;
  assign scl_rise = line_rise[L_SCL];
  assign scl_fall = line_fall[L_SCL];
  assign sda_lvl  = line_lvl[L_SDA];

  i2c_dt_cond u_cond (
    .scl_lvl  (line_lvl[L_SCL]),
    .sda_rise (line_rise[L_SDA]),
    .sda_fall (line_fall[L_SDA]),
    .start    (start),
    .stop     (stop)
  );

  // ---------------------------------------------------------------- state
  dt_state_e         state_q;
  dt_space_e         space_q, rs_space_q;
  logic              rw_q, rs_armed_q, mack_q, rd_vld_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] rd_buf_q;

  // ---------------------------------------------------------------- shifter
  logic              clr_cnt, tx_load, tx_shift, tx_next, byte_done, ack_phase;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;

  assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
  assign ack_phase = (state_q == ST_ID_ACK) || (state_q == ST_ADDR_ACK) ||
                     (state_q == ST_WDATA_ACK) || (state_q == ST_RACK);
  assign clr_cnt   = start | (scl_fall & ack_phase);
  assign tx_load   = scl_fall & (((state_q == ST_ID_ACK) & rw_q) |
                                 ((state_q == ST_RACK) & mack_q));
  assign tx_shift  = scl_fall & (state_q == ST_RDATA) & ~byte_done;

  i2c_dt_shift #(.BITS(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr_cnt  (clr_cnt),
    .rx_en    (scl_rise),
    .rx_bit   (sda_lvl),
    .tx_load  (tx_load),
    .tx_val   (rd_buf_q),
    .tx_shift (tx_shift),
    .rx_byte  (rx_byte),
    .tx_next  (tx_next),
    .bit_cnt  (bit_cnt)
  );

  // ---------------------------------------------------------------- identifier decode
  logic      hit_reg, hit_sram, id_read, id_ok;
  dt_space_e id_space;

  assign hit_reg  = (rx_byte[BYTE_W-1:1] == ID_REG);
  assign hit_sram = (rx_byte[BYTE_W-1:1] == ID_SRAM);
  assign id_read  = rx_byte[0];
  assign id_space = hit_sram ? SP_SRAM : SP_REG;
  // a read right after a dummy write must name the same space
  assign id_ok    = (hit_reg | hit_sram) &
                    ~(id_read & rs_armed_q & (id_space != rs_space_q));

  // ---------------------------------------------------------------- protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      space_q    <= SP_REG;
      rs_space_q <= SP_REG;
      rw_q       <= 1'b0;
      rs_armed_q <= 1'b0;
      mack_q     <= 1'b0;
      rd_vld_q   <= 1'b0;
      ptr_q      <= '0;
      rd_buf_q   <= '0;
      sda_oe     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_space  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_wr   <= 1'b0;
      mem_rd   <= 1'b0;
      rd_vld_q <= mem_rd;
      if (rd_vld_q) begin
        rd_buf_q <= mem_rdata;
      end

      if (stop) begin
        state_q    <= ST_IDLE;
        sda_oe     <= 1'b0;
        rs_armed_q <= 1'b0;
      end else if (start) begin
        state_q <= ST_ID;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          ST_ID: begin
            if (scl_fall && byte_done) begin
              if (id_ok) begin
                state_q    <= ST_ID_ACK;
                sda_oe     <= 1'b1;
                space_q    <= id_space;
                rw_q       <= id_read;
                rs_armed_q <= 1'b0;
                if (id_read) begin
                  mem_rd    <= 1'b1;
                  mem_addr  <= ptr_q;
                  mem_space <= id_space;
                end
              end else begin
                state_q <= ST_IGNORE;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_ID_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                sda_oe  <= ~rd_buf_q[BYTE_W-1];
              end else begin
                state_q <= ST_ADDR;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_ADDR: begin
            if (scl_fall && byte_done) begin
              state_q    <= ST_ADDR_ACK;
              sda_oe     <= 1'b1;
              ptr_q      <= rx_byte[ADDR_W-1:0];
              rs_armed_q <= 1'b1;
              rs_space_q <= space_q;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              state_q <= ST_WDATA;
              sda_oe  <= 1'b0;
            end
          end
          ST_WDATA: begin
            if (scl_fall && byte_done) begin
              state_q    <= ST_WDATA_ACK;
              sda_oe     <= 1'b1;
              rs_armed_q <= 1'b0;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_rise) begin
              mem_wr    <= 1'b1;
              mem_space <= space_q;
              mem_addr  <= ptr_q;
              mem_wdata <= rx_byte;
              ptr_q     <= ptr_q + 1'b1;
            end
            if (scl_fall) begin
              state_q <= ST_WDATA;
              sda_oe  <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (byte_done) begin
                state_q   <= ST_RACK;
                sda_oe    <= 1'b0;
                ptr_q     <= ptr_q + 1'b1;
                mem_rd    <= 1'b1;
                mem_addr  <= ptr_q + 1'b1;
                mem_space <= space_q;
              end else begin
                sda_oe <= ~tx_next;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end
            if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_RDATA;
                sda_oe  <= ~rd_buf_q[BYTE_W-1];
              end else begin
                state_q <= ST_IGNORE;
                sda_oe  <= 1'b0;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  // ---------------------------------------------------------------- assertions
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !sda_oe);

  a_r3_ignore_no_access: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> (!mem_wr && !mem_rd));

  a_r4_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r4_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));

  a_r5_ptr_after_write: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (ptr_q == ADDR_W'(mem_addr + 1'b1)));

  a_r9_ignore_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> !sda_oe);

  a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sda_oe);

endmodule

// File: tb/i2c_dual_target_tb_top.sv
module i2c_dual_target_tb_top;

  localparam int Q = 10;
  localparam logic [7:0] REG_W = 8'hDE;
  localparam logic [7:0] REG_R = 8'hDF;
  localparam logic [7:0] SR_W  = 8'hAE;
  localparam logic [7:0] SR_R  = 8'hAF;
  localparam logic [7:0] BAD_W = 8'h80;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, scl_m, sda_m;
  logic       sda_oe, mem_wr, mem_rd, mem_space;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_dual_target dut_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_space (mem_space),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] seed_val(input logic sp, input int a);
    return 8'(a * 7 + 3) ^ (sp ? 8'h5A : 8'hC3);
  endfunction

  // memory spaces behind the port
  logic [7:0] mem_m [0:1][0:255];
  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 256; a++) mem_m[s][a] <= seed_val(s[0], a);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_wr) mem_m[mem_space][mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem_m[mem_space][mem_addr];
    end
  end

  typedef struct packed {
    logic       sp;
    logic [7:0] a;
    logic [7:0] d;
  } wr_t;

  wr_t        exp_q[$];
  logic [7:0] shadow [0:1][0:255];
  int         checks = 0;
  int         errors = 0;
  logic       quiet = 1'b0;
  int         quiet_viol = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    wr_t want;
    if (!rst && mem_wr) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected write actual=%0h:%0h:%0h expected=none",
                 mem_space, mem_addr, mem_wdata);
      end else begin
        want = exp_q.pop_front();
        chk("R4 write item", 32'({mem_space, mem_addr, mem_wdata}), 32'(want));
      end
    end
    if (!rst && quiet && sda_oe) quiet_viol++;
  end

  task automatic exp_write(input logic sp, input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back(wr_t'{sp: sp, a: a, d: d});
    shadow[sp][a] = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = {d[6:0], b};
    end
    put_bit(~give_ack);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (whole run) actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         ones;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++) shadow[s][a] = seed_val(s[0], a);
    tick(5);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    chk("R1 sda_oe after reset", 32'(sda_oe), 32'd0);
    chk("R1 strobes after reset", 32'({mem_wr, mem_rd}), 32'd0);

    // R1 R6: read without address starts at 00h
    bus_start();
    put_byte(REG_R, ack); chk("R2 register read id ack", 32'(ack), 32'd1);
    get_byte(d, 1'b0);    chk("R1 R6 first read at 00h", 32'(d), 32'(shadow[0][0]));
    bus_stop();
    chk("R11 released after stop", 32'(sda_oe), 32'd0);

    // R4 R2: write two bytes into SRAM space
    bus_start();
    put_byte(SR_W, ack);  chk("R2 sram write id ack", 32'(ack), 32'd1);
    put_byte(8'h10, ack); chk("R4 address ack", 32'(ack), 32'd1);
    exp_write(1'b1, 8'h10, 8'hA5);
    put_byte(8'hA5, ack); chk("R4 data ack 1", 32'(ack), 32'd1);
    exp_write(1'b1, 8'h11, 8'h3C);
    put_byte(8'h3C, ack); chk("R4 data ack 2", 32'(ack), 32'd1);
    bus_stop();
    chk("R4 all writes seen", 32'(exp_q.size()), 32'd0);

    // R7: random read of register space, three sequential bytes
    bus_start();
    put_byte(REG_W, ack); chk("R7 dummy write id ack", 32'(ack), 32'd1);
    put_byte(8'h10, ack); chk("R7 dummy address ack", 32'(ack), 32'd1);
    bus_start();
    put_byte(REG_R, ack); chk("R7 read id ack", 32'(ack), 32'd1);
    get_byte(d, 1'b1);    chk("R7 byte at 10h", 32'(d), 32'(shadow[0][8'h10]));
    get_byte(d, 1'b1);    chk("R7 R5 byte at 11h", 32'(d), 32'(shadow[0][8'h11]));
    get_byte(d, 1'b0);    chk("R7 R5 byte at 12h", 32'(d), 32'(shadow[0][8'h12]));
    bus_stop();

    // R7 R4: random read back of the SRAM writes
    bus_start();
    put_byte(SR_W, ack);  chk("R7 sram dummy id ack", 32'(ack), 32'd1);
    put_byte(8'h10, ack); chk("R7 sram dummy address ack", 32'(ack), 32'd1);
    bus_start();
    put_byte(SR_R, ack);  chk("R7 sram read id ack", 32'(ack), 32'd1);
    get_byte(d, 1'b1);    chk("R7 R4 sram 10h holds A5", 32'(d), 32'h0A5);
    get_byte(d, 1'b0);    chk("R7 R4 sram 11h holds 3C", 32'(d), 32'h03C);
    bus_stop();

    // R5: write across FFh wraps to 00h, then current read at 01h
    bus_start();
    put_byte(REG_W, ack); chk("R5 id ack", 32'(ack), 32'd1);
    put_byte(8'hFE, ack); chk("R5 address ack", 32'(ack), 32'd1);
    exp_write(1'b0, 8'hFE, 8'h11); put_byte(8'h11, ack);
    exp_write(1'b0, 8'hFF, 8'h22); put_byte(8'h22, ack);
    exp_write(1'b0, 8'h00, 8'h33); put_byte(8'h33, ack);
    chk("R5 last data ack", 32'(ack), 32'd1);
    bus_stop();
    chk("R5 wrap writes seen", 32'(exp_q.size()), 32'd0);
    bus_start();
    put_byte(REG_R, ack);
    get_byte(d, 1'b0);    chk("R5 R6 current read after wrap at 01h", 32'(d), 32'(shadow[0][8'h01]));
    bus_stop();

    // R3: unknown identifier, following bytes ignored
    quiet = 1'b1;
    bus_start();
    put_byte(BAD_W, ack); chk("R3 unknown id not acked", 32'(ack), 32'd0);
    put_byte(8'h10, ack); put_byte(8'h77, ack);
    chk("R3 later byte not acked", 32'(ack), 32'd0);
    bus_stop();
    quiet = 1'b0;
    chk("R3 no SDA drive while ignored", 32'(quiet_viol), 32'd0);
    chk("R3 R11 released after stop", 32'(sda_oe), 32'd0);

    // R8: dummy write to register space, read names SRAM
    bus_start();
    put_byte(REG_W, ack);
    put_byte(8'h20, ack); chk("R8 dummy address ack", 32'(ack), 32'd1);
    bus_start();
    put_byte(SR_R, ack);  chk("R8 mismatched read id not acked", 32'(ack), 32'd0);
    bus_stop();
    bus_start();
    put_byte(REG_R, ack); chk("R8 matching read id acked", 32'(ack), 32'd1);
    get_byte(d, 1'b0);    chk("R8 R6 pointer kept at 20h", 32'(d), 32'(shadow[0][8'h20]));

    // R9: after master NACK the line stays released
    quiet = 1'b1;
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      logic b;
      get_bit(b);
      ones += int'(b);
    end
    chk("R9 line high after NACK", 32'(ones), 32'd9);
    bus_stop();
    quiet = 1'b0;
    chk("R9 no SDA drive after NACK", 32'(quiet_viol), 32'd0);

    // R10: aborted data bytes
    bus_start();
    put_byte(SR_W, ack);
    put_byte(8'h30, ack); chk("R10 address ack", 32'(ack), 32'd1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    bus_start();
    put_byte(SR_W, ack);
    put_byte(8'h31, ack); chk("R10 second address ack", 32'(ack), 32'd1);
    for (int i = 0; i < 7; i++) put_bit(1'b0);
    bus_start();
    put_byte(SR_R, ack);  chk("R10 read after cut byte acked", 32'(ack), 32'd1);
    get_byte(d, 1'b0);    chk("R10 location 31h untouched", 32'(d), 32'(shadow[1][8'h31]));
    bus_stop();
    tick(20);
    chk("R10 no write from cut bytes", 32'(exp_q.size()), 32'd0);
    chk("R11 idle line released", 32'(sda_oe), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule